// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the SCL clock of an I2C master. A 32-bit timing word gives a power-of-two prescale exponent and two 4-bit phase lengths, one for the low half of the bit period and one for the high half. While enabled, the block steps through a low phase, in which it asks the pad to pull SCL down, then releases the line and waits for SCL to read high, then counts the high phase. Single-cycle strobes tell the bit engine when to change SDA (halfway through the low phase), when to sample SDA (halfway through the high phase), and when each phase ends.

A slave that holds SCL low after the release stretches the period: the high-phase count does not start until the sampled line reads high. The timing word is captured at the start of every bit period, so software may rewrite it at any time without corrupting the period in progress.

A separate combinational helper turns a requested divide ratio (peripheral clock over bus rate) into a timing word in the same format. It halves the ratio until it fits in four bits, counts the halvings as the exponent and rounds up if any discarded bit was set. The low and high fields are then split from the reduced ratio.

Top module: `scl_timing_gen`

## Requirements
- R1: After a synchronous reset, and on every cycle while `enable` is low, `scl_drive_low` and all four tick outputs are 0.
- R2: The timing word holds the low length L in bits 15:12 and the exponent E in bits 3:0. Once enabled, `scl_drive_low` is 1 for exactly (L+1)·2^E consecutive cycles per bit period, starting the cycle after `enable` is first seen high.
- R3: The timing word holds the high length H in bits 19:16. The high phase lasts (H+1)·2^E cycles and starts on the cycle after the one in which `scl_in` is first seen high following a release. It is followed directly by the next low phase.
- R4: While `scl_in` stays low after the release (clock stretching), `scl_drive_low` stays 0 and no tick is issued.
- R5: `tick_drive` pulses for one cycle in each low phase, on the cycle whose zero-based index within the phase equals floor(P/2), where P is the phase length in cycles.
- R6: `tick_sample` pulses for one cycle in each high phase, on the cycle whose zero-based index equals floor(P/2).
- R7: `tick_release` marks the last cycle of each low phase and `tick_period` marks the last cycle of each high phase.
- R8: The timing word is captured only when a low phase begins. A change made during a bit period has no effect until the next period.
- R9: Bits of the timing word outside 19:12 and 3:0 have no effect on the SCL phases.
- R10: For a ratio of 2 or more, `conv_word` bits 3:0 hold the number of halvings needed to bring the ratio below 16. The reduced ratio is incremented by one if any discarded bit was 1.
- R11: With r the rounded reduced ratio, `conv_word` bits 15:12 equal floor(r/2)−1 and bits 19:16 equal r minus that value minus 2. All other bits equal the fixed pattern 0x77700300.
- R12: Clearing `enable` in any phase returns the block to idle on the next cycle. Setting it again starts a fresh low phase from its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run SCL generation |
| timing_word | input | 32 | Exponent (3:0), low length (15:12), high length (19:16) |
| scl_in | input | 1 | Synchronised level of the SCL line |
| scl_drive_low | output | 1 | Request to pull SCL low |
| tick_drive | output | 1 | Midpoint of the low phase: change SDA |
| tick_release | output | 1 | Last cycle of the low phase |
| tick_sample | output | 1 | Midpoint of the high phase: sample SDA |
| tick_period | output | 1 | Last cycle of the high phase |
| ratio_in | input | RATIO_W | Requested divide ratio for the helper |
| conv_word | output | 32 | Timing word derived from `ratio_in` |

## Verification
The phase generator is run with an exponent of zero and asymmetric lengths, which separates low-length from high-length errors. A larger exponent with junk in the unused word bits shows whether the prescaler and the field decode are right. Zero lengths make the midpoint and end strobes coincide. A stretching bus model that holds SCL low for several cycles tells a correct wait from a count that starts at the release. The word is rewritten mid-period and `enable` is dropped mid-phase to expose capture and restart errors. The helper is fed ratios on both sides of 16 and 32 and just past a power of two, where sticky rounding changes the result, as well as the widest input value.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int FIELD_W   = 4;                        // phase length field width
    localparam int EXP_W     = 4;                        // prescale exponent width
    localparam int PRESC_W   = (1 << EXP_W) - 1;         // widest prescale count
    localparam int ELAPSED_W = FIELD_W + PRESC_W + 1;    // cycles within a phase
    localparam int FIT_LIMIT = 1 << FIELD_W;             // ratio must drop below this

    localparam logic [31:0] WORD_FILL = 32'h7770_0300;

    typedef struct packed {
        logic [11:0]        rsv_top;
        logic [FIELD_W-1:0] hi_len;    // bits 19:16
        logic [FIELD_W-1:0] lo_len;    // bits 15:12
        logic [7:0]         rsv_mid;
        logic [EXP_W-1:0]   div_exp;   // bits 3:0
    } scl_word_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    // Number of system cycles in a phase of programmed length len
    function automatic logic [ELAPSED_W-1:0] phase_clocks(
        input logic [FIELD_W-1:0] len,
        input logic [EXP_W-1:0]   ex
    );
        return (ELAPSED_W'(len) + ELAPSED_W'(1)) << ex;
    endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_timing_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic [EXP_W-1:0]   div_exp,
    output logic               base_tick,
    output logic [PRESC_W-1:0] sub_cnt
);

    logic [PRESC_W-1:0] cnt_q;
    logic [PRESC_W-1:0] wrap_at;

    // 2^exp - 1; for the largest exponent the shift wraps to zero and the
    // subtraction yields all ones, which is the intended terminal count.
    assign wrap_at   = (PRESC_W'(1) << div_exp) - PRESC_W'(1);
    assign base_tick = (cnt_q == wrap_at);
    assign sub_cnt   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear || base_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRESC_W'(1);
        end
    end

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_timing_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  scl_word_t          word_in,
    input  logic               scl_in,
    input  logic               base_tick,
    input  logic [PRESC_W-1:0] sub_cnt,
    output logic               clear,
    output logic [EXP_W-1:0]   cfg_exp,
    output logic               scl_drive_low,
    output logic               tick_drive,
    output logic               tick_release,
    output logic               tick_sample,
    output logic               tick_period
);

    scl_phase_e         st_q, st_d;
    logic [FIELD_W-1:0] lo_q, hi_q, k_q;
    logic [EXP_W-1:0]   ex_q;
    logic               load_cfg, counting, at_last, at_mid;
    logic [FIELD_W-1:0] cur_len;
    logic [ELAPSED_W-1:0] span, elapsed;
    logic               unused_rsv;

    assign unused_rsv = ^{word_in.rsv_top, word_in.rsv_mid};

    assign counting = (st_q == PH_LOW) || (st_q == PH_HIGH);
    assign cur_len  = (st_q == PH_HIGH) ? hi_q : lo_q;
    assign span     = phase_clocks(cur_len, ex_q);
    assign elapsed  = (ELAPSED_W'(k_q) << ex_q) | ELAPSED_W'(sub_cnt);
    assign at_last  = counting && (elapsed == span - ELAPSED_W'(1));
    assign at_mid   = counting && (elapsed == (span >> 1));
    assign clear    = !counting || at_last;
    assign cfg_exp  = ex_q;

    always_comb begin
        st_d     = st_q;
        load_cfg = 1'b0;
        if (!enable) begin
            st_d = PH_IDLE;
        end else begin
            case (st_q)
                PH_IDLE: begin
                    st_d     = PH_LOW;
                    load_cfg = 1'b1;
                end
                PH_LOW:  if (at_last) st_d = PH_WAIT;
                PH_WAIT: if (scl_in)  st_d = PH_HIGH;
                PH_HIGH: if (at_last) begin
                    st_d     = PH_LOW;
                    load_cfg = 1'b1;
                end
                default: st_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PH_IDLE;
            lo_q <= '0;
            hi_q <= '0;
            ex_q <= '0;
            k_q  <= '0;
        end else begin
            st_q <= st_d;
            if (load_cfg) begin
                lo_q <= word_in.lo_len;
                hi_q <= word_in.hi_len;
                ex_q <= word_in.div_exp;
            end
            if (clear) begin
                k_q <= '0;
            end else if (base_tick) begin
                k_q <= k_q + FIELD_W'(1);
            end
        end
    end

    assign scl_drive_low = (st_q == PH_LOW);
    assign tick_drive    = (st_q == PH_LOW)  && at_mid;
    assign tick_release  = (st_q == PH_LOW)  && at_last;
    assign tick_sample   = (st_q == PH_HIGH) && at_mid;
    assign tick_period   = (st_q == PH_HIGH) && at_last;

endmodule

// File: rtl/scl_ratio_conv.sv
module scl_ratio_conv
    import scl_timing_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input  logic [RATIO_W-1:0] ratio_in,
    output logic [31:0]        word_out
);

    logic [RATIO_W-1:0] red;
    logic [EXP_W-1:0]   ex;
    logic               sticky;
    logic [FIELD_W:0]   lo_v, hi_v;
    scl_word_t          fields;

    always_comb begin
        red    = ratio_in;
        ex     = '0;
        sticky = 1'b0;
        for (int i = 0; i < RATIO_W; i++) begin
            if (red >= RATIO_W'(FIT_LIMIT)) begin
                sticky = sticky | red[0];
                red    = red >> 1;
                ex     = ex + EXP_W'(1);
            end
        end
        red  = red + RATIO_W'(sticky);
        lo_v = (red[FIELD_W:0] >> 1) - (FIELD_W+1)'(1);
        hi_v = red[FIELD_W:0] - lo_v - (FIELD_W+1)'(2);

        fields         = '0;
        fields.hi_len  = hi_v[FIELD_W-1:0];
        fields.lo_len  = lo_v[FIELD_W-1:0];
        fields.div_exp = ex;
        word_out       = WORD_FILL | fields;
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [31:0]        timing_word,
    input  logic               scl_in,
    output logic               scl_drive_low,
    output logic               tick_drive,
    output logic               tick_release,
    output logic               tick_sample,
    output logic               tick_period,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic [31:0]        conv_word
);

    logic               clear, base_tick;
    logic [EXP_W-1:0]   cfg_exp;
    logic [PRESC_W-1:0] sub_cnt;

    scl_prescaler presc_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .div_exp   (cfg_exp),
        .base_tick (base_tick),
        .sub_cnt   (sub_cnt)
    );

    scl_phase_ctrl phase_i (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .word_in       (scl_word_t'(timing_word)),
        .scl_in        (scl_in),
        .base_tick     (base_tick),
        .sub_cnt       (sub_cnt),
        .clear         (clear),
        .cfg_exp       (cfg_exp),
        .scl_drive_low (scl_drive_low),
        .tick_drive    (tick_drive),
        .tick_release  (tick_release),
        .tick_sample   (tick_sample),
        .tick_period   (tick_period)
    );

    scl_ratio_conv #(.RATIO_W(RATIO_W)) conv_i (
        .ratio_in (ratio_in),
        .word_out (conv_word)
    );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk #(
    parameter int RATIO_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               scl_in,
    input logic               scl_drive_low,
    input logic               tick_drive,
    input logic               tick_release,
    input logic               tick_sample,
    input logic               tick_period,
    input logic [RATIO_W-1:0] ratio_in,
    input logic [31:0]        conv_word
);

    assert_drive_in_low_R5: assert property (@(posedge clk) disable iff (rst)
        tick_drive |-> scl_drive_low);

    assert_sample_released_R6: assert property (@(posedge clk) disable iff (rst)
        tick_sample |-> !scl_drive_low);

    assert_release_then_up_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_release && enable) |=> !scl_drive_low);

    assert_period_then_low_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_period && enable) |=> scl_drive_low);

    assert_disable_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!scl_drive_low && !tick_drive && !tick_sample));

    assert_stretch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_drive_low) && !scl_in && enable) |=> (!scl_drive_low && !tick_sample));

    assert_conv_fill_R11: assert property (@(posedge clk) disable iff (rst)
        (conv_word & 32'hFFF0_0FF0) == 32'h7770_0300);

    assert_conv_balance_R11: assert property (@(posedge clk) disable iff (rst)
        (ratio_in >= RATIO_W'(16)) |->
            ((conv_word[19:16] == conv_word[15:12]) ||
             (conv_word[19:16] == conv_word[15:12] + 4'd1)));

endmodule

bind scl_timing_gen scl_timing_gen_chk #(.RATIO_W(RATIO_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .tick_drive    (tick_drive),
    .tick_release  (tick_release),
    .tick_sample   (tick_sample),
    .tick_period   (tick_period),
    .ratio_in      (ratio_in),
    .conv_word     (conv_word)
);

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;

    localparam int RATIO_W = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               enable = 1'b0;
    logic               scl_in = 1'b1;
    logic [31:0]        timing_word = '0;
    logic [RATIO_W-1:0] ratio_in = RATIO_W'(2);
    logic               scl_drive_low, tick_drive, tick_release, tick_sample, tick_period;
    logic [31:0]        conv_word;

    scl_timing_gen #(.RATIO_W(RATIO_W)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .timing_word(timing_word),
        .scl_in(scl_in), .scl_drive_low(scl_drive_low), .tick_drive(tick_drive),
        .tick_release(tick_release), .tick_sample(tick_sample),
        .tick_period(tick_period), .ratio_in(ratio_in), .conv_word(conv_word)
    );

    always #5 clk = ~clk;   // 100 MHz

    int    n_cmp = 0;
    int    n_bad = 0;
    string req = "R1";
    // reference model: 0 idle, 1 low, 2 waiting for SCL high, 3 high
    int    m_st = 0, m_e = 0, m_lo = 0, m_hi = 0, m_ex = 0;
    int    stretch_cfg = 0, stretch_left = 0;

    function automatic int plen(int n, int ex);
        return (n + 1) * (1 << ex);
    endfunction

    function automatic logic [31:0] ref_conv(int ratio);
        int ex = 0;
        int r, lo, hi;
        while ((ratio >> ex) >= 16) ex++;
        r = ratio >> ex;
        if ((ratio % (1 << ex)) != 0) r++;
        lo = r / 2 - 1;
        hi = r - lo - 2;
        return 32'h7770_0300 | 32'(hi << 16) | 32'(lo << 12) | 32'(ex);
    endfunction

    task automatic chk(string sig, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, sig, act, exp);
        end
    endtask

    task automatic latch_word();
        m_lo = int'(timing_word[15:12]);
        m_hi = int'(timing_word[19:16]);
        m_ex = int'(timing_word[3:0]);
    endtask

    task automatic model_update();
        if (rst) begin
            m_st = 0; m_e = 0; m_lo = 0; m_hi = 0; m_ex = 0;
        end else if (!enable) begin
            m_st = 0; m_e = 0;
        end else if (m_st == 0) begin
            m_st = 1; m_e = 0; latch_word();
        end else if (m_st == 1) begin
            if (m_e == plen(m_lo, m_ex) - 1) begin m_st = 2; m_e = 0; end
            else m_e++;
        end else if (m_st == 2) begin
            if (scl_in) begin m_st = 3; m_e = 0; end
        end else begin
            if (m_e == plen(m_hi, m_ex) - 1) begin m_st = 1; m_e = 0; latch_word(); end
            else m_e++;
        end
    endtask

    task automatic step();
        int pl, ph;
        model_update();
        @(negedge clk);
        pl = plen(m_lo, m_ex);
        ph = plen(m_hi, m_ex);
        chk("scl_drive_low", 32'(scl_drive_low), 32'(m_st == 1));
        chk("tick_drive",    32'(tick_drive),    32'(m_st == 1 && m_e == pl / 2));
        chk("tick_release",  32'(tick_release),  32'(m_st == 1 && m_e == pl - 1));
        chk("tick_sample",   32'(tick_sample),   32'(m_st == 3 && m_e == ph / 2));
        chk("tick_period",   32'(tick_period),   32'(m_st == 3 && m_e == ph - 1));
        chk("conv_word",     conv_word,          ref_conv(int'(ratio_in)));
        // bus model: line follows the pull-down, a slave may hold it low longer
        if (scl_drive_low) begin
            scl_in = 1'b0;
            stretch_left = stretch_cfg;
        end else if (stretch_left > 0) begin
            scl_in = 1'b0;
            stretch_left--;
        end else begin
            scl_in = 1'b1;
        end
    endtask

    initial begin
        // R1: reset and disabled state
        req = "R1";
        repeat (3) step();
        rst = 1'b0;
        repeat (3) step();

        // R2 R3 R5 R6 R7: exponent 0, low 3, high 2
        req = "R2 R3 R5 R6 R7";
        timing_word = 32'h0002_3000;
        enable = 1'b1;
        repeat (40) step();

        // R9: exponent 2, low 1, high 4, junk in unused bits
        req = "R9 R2 R3";
        timing_word = 32'hFFF4_1FF2;
        repeat (90) step();

        // R4: slave stretches SCL for 7 cycles after each release
        req = "R4";
        stretch_cfg = 7;
        repeat (90) step();
        stretch_cfg = 0;

        // R8: word rewritten in the middle of a bit period
        req = "R8";
        repeat (5) step();
        timing_word = 32'h0001_5001;
        repeat (3) step();
        timing_word = 32'h0003_2000;
        repeat (60) step();

        // R12: disable mid-phase, then restart with zero lengths (R5 R7 corner)
        req = "R12";
        enable = 1'b0;
        repeat (4) step();
        req = "R12 R5 R7";
        timing_word = 32'h0000_0000;
        enable = 1'b1;
        repeat (20) step();

        // larger exponent
        req = "R2 R3 R6";
        timing_word = 32'h0001_2005;
        repeat (400) step();

        // R10 R11: ratio conversion, including rounding boundaries
        req = "R10 R11";
        foreach (ratio_list[i]) begin
            ratio_in = ratio_list[i];
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [RATIO_W-1:0] ratio_list [14] = '{
        16'd2, 16'd3, 16'd7, 16'd15, 16'd16, 16'd17, 16'd31,
        16'd32, 16'd33, 16'd100, 16'd250, 16'd1000, 16'd4097, 16'd65535
    };

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule